// File: doc/BRIEF.md
# VLIW Packet Framer

This block takes the 32-bit words of a fetch stream over a valid/ready handshake and groups them into one execution packet. Bits [15:14] of every word form a two-bit parse field. That field tells the block whether the word closes the packet, whether it is a duplex word, and whether it carries a hardware-loop end marker. A side-band flag on each word marks it as a constant extender. The block folds an extender into the immediate of the next instruction and does not give it an instruction slot of its own.

When a packet closes, the block presents a packet descriptor for exactly one cycle. The descriptor holds:
- the number of words consumed and the size in bytes;
- the number of instructions;
- one immediate per instruction slot, each with a flag that says whether an extender widened it;
- a duplex flag;
- two loop-end flags.

A decode stage reads the descriptor. Opcode decoding and slot assignment are done further down the pipeline. If the stream dries up part-way through a packet, a drain pulse closes the packet as incomplete.

Top module: `vliw_packet_framer`

## Requirements
- R1: A word whose parse field is 11 (binary) or 00 closes the packet. Parse fields 01 and 10 do not close it. pkt_valid is high for exactly the one cycle after the clock edge that accepted the closing word. in_ready is low during that cycle.
- R2: pkt_duplex is 1 when the closing word had parse field 00, and 0 when it had parse field 11.
- R3: In a packet of exactly two words, pkt_endloop0 is 1 when word 0 has parse field 10, and pkt_endloop1 is 0. A packet of one word raises neither flag.
- R4: In a packet of three or more words, pkt_endloop0 reflects parse field 10 in word 0 and pkt_endloop1 reflects parse field 10 in word 1. The two are independent, so both may be set. These positions count extender words.
- R5: An instruction word without a pending extender gets the immediate zero-extended word[13:0], and its pkt_ext bit is 0. An instruction word that follows an extender gets the immediate {E[27:16], E[13:0], 6'b0} OR word[5:0], where E is the extender word, and its pkt_ext bit is 1. Slot k of pkt_imm is bits [32k+31:32k].
- R6: Extender words take no slot. pkt_insns equals pkt_words minus the number of extender words, and instructions fill slots 0, 1, ... in arrival order.
- R7: When in_drain is high on a cycle with no accepted word and at least one word has been collected, the next cycle shows pkt_valid with pkt_incomplete=1, pkt_words=0, pkt_insns=0 and all loop flags clear. When nothing has been collected, in_drain has no effect.
- R8: A fifth instruction word, or an extender that follows an extender, closes the packet at once with pkt_error=1. pkt_words counts the offending word, and pkt_insns stays at most 4.
- R9: pkt_bytes equals four times pkt_words.
- R10: After reset, pkt_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word on in_word is offered |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 32 | Fetched instruction word |
| in_is_ext | input | 1 | Offered word is a constant extender |
| in_drain | input | 1 | Fetch supply has run out |
| pkt_valid | output | 1 | Descriptor valid (one-cycle pulse) |
| pkt_incomplete | output | 1 | Packet closed by drain before its end word |
| pkt_error | output | 1 | Slot overflow or back-to-back extenders |
| pkt_words | output | 4 | Words consumed |
| pkt_bytes | output | 6 | Bytes consumed |
| pkt_insns | output | 3 | Instructions in the packet |
| pkt_imm | output | 128 | Per-slot immediates, slot 0 in the low bits |
| pkt_ext | output | 4 | Per-slot extended flags |
| pkt_duplex | output | 1 | Closing word was a duplex |
| pkt_endloop0 | output | 1 | Packet ends hardware loop 0 |
| pkt_endloop1 | output | 1 | Packet ends hardware loop 1 |

## Verification
Every descriptor field becomes visible one cycle after the edge that accepted the closing word, or one cycle after the edge that sampled in_drain. The bench drives inputs on the falling edge and keeps in_valid up through the accepting edge. It reads the descriptor on the next falling edge, which is the middle of the single pulse. It then waits out the cycle in which in_ready is low before it offers the next packet. The drain-when-idle case is read on that same next falling edge, where pkt_valid must still be low.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  localparam int PARSE_HI = 15;
  localparam int PARSE_LO = 14;

  typedef enum logic [1:0] {
    PF_PAIR = 2'b00,
    PF_MID  = 2'b01,
    PF_LOOP = 2'b10,
    PF_LAST = 2'b11
  } parse_e;

  typedef struct packed {
    logic closes;
    logic duplex;
    logic marker;
  } wclass_t;

endpackage

// File: rtl/pfr_classify.sv
module pfr_classify
  import pfr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output wclass_t           cls
);
  parse_e pf;

  always_comb begin
    pf         = parse_e'(word[PARSE_HI:PARSE_LO]);
    cls.closes = (pf == PF_LAST) || (pf == PF_PAIR);
    cls.duplex = (pf == PF_PAIR);
    cls.marker = (pf == PF_LOOP);
  end
endmodule

// File: rtl/pfr_merge.sv
module pfr_merge #(
  parameter int WORD_W   = 32,
  parameter int FIELD_W  = 14,
  parameter int KEEP_LOW = 6,
  parameter int UPPER_LO = 16
) (
  input  logic [WORD_W-1:0] word,
  input  logic              pend,
  input  logic [WORD_W-1:0] pend_val,
  output logic [WORD_W-1:0] imm,
  output logic [WORD_W-1:0] ext_val
);
  localparam int HI_W = WORD_W - KEEP_LOW - FIELD_W;

  always_comb begin
    ext_val = {word[UPPER_LO+HI_W-1:UPPER_LO], word[FIELD_W-1:0], {KEEP_LOW{1'b0}}};
    if (pend) begin
      imm = pend_val | {{(WORD_W-KEEP_LOW){1'b0}}, word[KEEP_LOW-1:0]};
    end else begin
      imm = {{(WORD_W-FIELD_W){1'b0}}, word[FIELD_W-1:0]};
    end
  end
endmodule

// File: rtl/pfr_collect.sv
module pfr_collect
  import pfr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MAX_SLOTS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              acc,
  input  wclass_t                           cls,
  input  logic                              is_ext,
  input  logic [WORD_W-1:0]                 merged_imm,
  input  logic [WORD_W-1:0]                 word_ext_val,
  input  logic                              drain,
  output logic                              pend_q,
  output logic [WORD_W-1:0]                 pend_val_q,
  output logic                              o_valid,
  output logic                              o_incomplete,
  output logic                              o_error,
  output logic [$clog2(2*MAX_SLOTS+2)-1:0]  o_words,
  output logic [$clog2(2*MAX_SLOTS+2)+1:0]  o_bytes,
  output logic [$clog2(MAX_SLOTS+1)-1:0]    o_insns,
  output logic [MAX_SLOTS-1:0][WORD_W-1:0]  o_imm,
  output logic [MAX_SLOTS-1:0]              o_ext,
  output logic                              o_duplex,
  output logic                              o_loop0,
  output logic                              o_loop1
);
  localparam int MAX_WORDS = 2 * MAX_SLOTS + 1;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);
  localparam int BYTE_W    = CNT_W + 2;

  // collection state
  logic [CNT_W-1:0]                 words_q, words_n;
  logic [SLOT_W-1:0]                insns_q, insns_n;
  logic [MAX_SLOTS-1:0][WORD_W-1:0] imm_q, imm_n;
  logic [MAX_SLOTS-1:0]             xf_q, xf_n;
  logic                             pend_n;
  logic [WORD_W-1:0]                pend_val_n;
  logic                             mark0_q, mark0_n, mark1_q, mark1_n;

  // close decision
  logic close, err, incomp;

  always_comb begin
    words_n    = words_q;
    insns_n    = insns_q;
    imm_n      = imm_q;
    xf_n       = xf_q;
    pend_n     = pend_q;
    pend_val_n = pend_val_q;
    mark0_n    = mark0_q;
    mark1_n    = mark1_q;
    close      = 1'b0;
    err        = 1'b0;
    incomp     = 1'b0;
    if (acc) begin
      words_n = words_q + CNT_W'(1);
      if (words_q == CNT_W'(0)) mark0_n = cls.marker;
      if (words_q == CNT_W'(1)) mark1_n = cls.marker;
      if (is_ext) begin
        if (pend_q) begin
          close = 1'b1;
          err   = 1'b1;
        end else begin
          pend_n     = 1'b1;
          pend_val_n = word_ext_val;
        end
      end else if (insns_q == SLOT_W'(MAX_SLOTS)) begin
        close = 1'b1;
        err   = 1'b1;
      end else begin
        for (int s = 0; s < MAX_SLOTS; s++) begin
          if (insns_q == SLOT_W'(s)) begin
            imm_n[s] = merged_imm;
            xf_n[s]  = pend_q;
          end
        end
        pend_n  = 1'b0;
        insns_n = insns_q + SLOT_W'(1);
        close   = cls.closes;
      end
    end else if (drain && (words_q != CNT_W'(0))) begin
      close  = 1'b1;
      incomp = 1'b1;
    end
  end

  // descriptor next values
  logic [CNT_W-1:0]                 ow_n;
  logic [SLOT_W-1:0]                oi_n;
  logic [MAX_SLOTS-1:0][WORD_W-1:0] oimm_n;
  logic [MAX_SLOTS-1:0]             oxf_n;
  logic                             odup_n, ol0_n, ol1_n;

  always_comb begin
    ow_n   = incomp ? '0 : words_n;
    oi_n   = incomp ? '0 : insns_n;
    oimm_n = incomp ? '0 : imm_n;
    oxf_n  = incomp ? '0 : xf_n;
    odup_n = !incomp && !err && !is_ext && cls.duplex;
    ol0_n  = !incomp && mark0_n && (words_n >= CNT_W'(2));
    ol1_n  = !incomp && mark1_n && (words_n >= CNT_W'(3));
  end

  // collection registers, cleared on close
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q    <= '0;
      insns_q    <= '0;
      imm_q      <= '0;
      xf_q       <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
      mark0_q    <= 1'b0;
      mark1_q    <= 1'b0;
    end else if (close) begin
      words_q    <= '0;
      insns_q    <= '0;
      imm_q      <= '0;
      xf_q       <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
      mark0_q    <= 1'b0;
      mark1_q    <= 1'b0;
    end else if (acc) begin
      words_q    <= words_n;
      insns_q    <= insns_n;
      imm_q      <= imm_n;
      xf_q       <= xf_n;
      pend_q     <= pend_n;
      pend_val_q <= pend_val_n;
      mark0_q    <= mark0_n;
      mark1_q    <= mark1_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_valid <= 1'b0;
    else        o_valid <= close;
  end

  // descriptor registers, enabled on close
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_incomplete <= 1'b0;
      o_error      <= 1'b0;
      o_words      <= '0;
      o_bytes      <= '0;
      o_insns      <= '0;
      o_imm        <= '0;
      o_ext        <= '0;
      o_duplex     <= 1'b0;
      o_loop0      <= 1'b0;
      o_loop1      <= 1'b0;
    end else if (close) begin
      o_incomplete <= incomp;
      o_error      <= err;
      o_words      <= ow_n;
      o_bytes      <= {ow_n, 2'b00};
      o_insns      <= oi_n;
      o_imm        <= oimm_n;
      o_ext        <= oxf_n;
      o_duplex     <= odup_n;
      o_loop0      <= ol0_n;
      o_loop1      <= ol1_n;
    end
  end

  // R1
  end_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_ext && cls.closes && (insns_q < SLOT_W'(MAX_SLOTS))) |=> o_valid);
  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |=> !o_valid);
  // R4
  loop1_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_loop1) |-> (o_words >= CNT_W'(3)));
  // R6
  slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> ((o_insns <= SLOT_W'(MAX_SLOTS)) && (CNT_W'(o_insns) <= o_words)));
  // R7
  incomplete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_incomplete) |-> ((o_words == '0) && !o_loop0 && !o_loop1));
  // R9
  byte_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_bytes == BYTE_W'(o_words) * BYTE_W'(4)));
endmodule

// File: rtl/vliw_packet_framer.sv
module vliw_packet_framer
  import pfr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MAX_SLOTS = 4,
  parameter int FIELD_W   = 14,
  parameter int KEEP_LOW  = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic [WORD_W-1:0]                     in_word,
  input  logic                                  in_is_ext,
  input  logic                                  in_drain,
  output logic                                  pkt_valid,
  output logic                                  pkt_incomplete,
  output logic                                  pkt_error,
  output logic [$clog2(2*MAX_SLOTS+2)-1:0]      pkt_words,
  output logic [$clog2(2*MAX_SLOTS+2)+1:0]      pkt_bytes,
  output logic [$clog2(MAX_SLOTS+1)-1:0]        pkt_insns,
  output logic [MAX_SLOTS*WORD_W-1:0]           pkt_imm,
  output logic [MAX_SLOTS-1:0]                  pkt_ext,
  output logic                                  pkt_duplex,
  output logic                                  pkt_endloop0,
  output logic                                  pkt_endloop1
);
  wclass_t                          cls;
  logic                             acc;
  logic                             pend;
  logic [WORD_W-1:0]                pend_val, merged, wext;
  logic [MAX_SLOTS-1:0][WORD_W-1:0] imm_arr;

  assign in_ready = !pkt_valid;
  assign acc      = in_valid && in_ready;
  assign pkt_imm  = imm_arr;

  pfr_classify #(.WORD_W(WORD_W)) u_cls (
    .word (in_word),
    .cls  (cls)
  );

  pfr_merge #(
    .WORD_W  (WORD_W),
    .FIELD_W (FIELD_W),
    .KEEP_LOW(KEEP_LOW),
    .UPPER_LO(PARSE_HI + 1)
  ) u_merge (
    .word     (in_word),
    .pend     (pend),
    .pend_val (pend_val),
    .imm      (merged),
    .ext_val  (wext)
  );

  pfr_collect #(.WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS)) u_col (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc          (acc),
    .cls          (cls),
    .is_ext       (in_is_ext),
    .merged_imm   (merged),
    .word_ext_val (wext),
    .drain        (in_drain),
    .pend_q       (pend),
    .pend_val_q   (pend_val),
    .o_valid      (pkt_valid),
    .o_incomplete (pkt_incomplete),
    .o_error      (pkt_error),
    .o_words      (pkt_words),
    .o_bytes      (pkt_bytes),
    .o_insns      (pkt_insns),
    .o_imm        (imm_arr),
    .o_ext        (pkt_ext),
    .o_duplex     (pkt_duplex),
    .o_loop0      (pkt_endloop0),
    .o_loop1      (pkt_endloop1)
  );
endmodule

// File: tb/vliw_packet_framer_bench.sv
module vliw_packet_framer_bench;
  typedef struct packed {
    logic [2:0]        n;
    logic [4:0]        ext;
    logic [4:0][31:0]  w;
    logic [2:0]        e_insns;
    logic              e_l0;
    logic              e_l1;
    logic              e_dup;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{n:3'd1, ext:5'b00000, w:{32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_C123},
      e_insns:3'd1, e_l0:1'b0, e_l1:1'b0, e_dup:1'b0},
    '{n:3'd1, ext:5'b00000, w:{32'h0, 32'h0, 32'h0, 32'h0, 32'h1234_0ABC},
      e_insns:3'd1, e_l0:1'b0, e_l1:1'b0, e_dup:1'b1},
    '{n:3'd2, ext:5'b00000, w:{32'h0, 32'h0, 32'h0, 32'h0000_C022, 32'h0000_8011},
      e_insns:3'd2, e_l0:1'b1, e_l1:1'b0, e_dup:1'b0},
    '{n:3'd3, ext:5'b00000, w:{32'h0, 32'h0, 32'h0000_C003, 32'h0000_8002, 32'h0000_8001},
      e_insns:3'd3, e_l0:1'b1, e_l1:1'b1, e_dup:1'b0},
    '{n:3'd3, ext:5'b00000, w:{32'h0, 32'h0, 32'h0000_0003, 32'h0000_8002, 32'h0000_4001},
      e_insns:3'd3, e_l0:1'b0, e_l1:1'b1, e_dup:1'b1},
    '{n:3'd2, ext:5'b00001, w:{32'h0, 32'h0, 32'h0, 32'h0000_C07F, 32'h0ABC_4321},
      e_insns:3'd1, e_l0:1'b0, e_l1:1'b0, e_dup:1'b0},
    '{n:3'd5, ext:5'b00010, w:{32'h0000_C005, 32'h0000_4004, 32'h0000_4003, 32'h0001_8002, 32'h0000_8001},
      e_insns:3'd4, e_l0:1'b1, e_l1:1'b1, e_dup:1'b0}
  };

  logic         clk, rst_n;
  logic         in_valid, in_ready, in_is_ext, in_drain;
  logic [31:0]  in_word;
  logic         pkt_valid, pkt_incomplete, pkt_error, pkt_duplex, pkt_endloop0, pkt_endloop1;
  logic [3:0]   pkt_words;
  logic [5:0]   pkt_bytes;
  logic [2:0]   pkt_insns;
  logic [127:0] pkt_imm;
  logic [3:0]   pkt_ext;

  int n_chk = 0;
  int n_fail = 0;

  vliw_packet_framer u_vliw_packet_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_is_ext(in_is_ext), .in_drain(in_drain),
    .pkt_valid(pkt_valid), .pkt_incomplete(pkt_incomplete), .pkt_error(pkt_error),
    .pkt_words(pkt_words), .pkt_bytes(pkt_bytes), .pkt_insns(pkt_insns),
    .pkt_imm(pkt_imm), .pkt_ext(pkt_ext), .pkt_duplex(pkt_duplex),
    .pkt_endloop0(pkt_endloop0), .pkt_endloop1(pkt_endloop1)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  // drive words on falling edges; the last word is accepted at the next rising edge
  task automatic send(input int n, input logic [4:0] ext, input logic [4:0][31:0] w);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_word   = w[i];
      in_is_ext = ext[i];
      @(posedge clk);
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_is_ext = 1'b0;
  endtask

  // expected immediates and extended flags from R5/R6
  task automatic check_imms(input int n, input logic [4:0] ext, input logic [4:0][31:0] w, input string tag);
    logic [3:0][31:0] eimm;
    logic [3:0]       ex;
    logic             pend;
    logic [31:0]      pv;
    int               slot;
    eimm = '0; ex = '0; pend = 1'b0; pv = '0; slot = 0;
    for (int i = 0; i < n; i++) begin
      if (ext[i]) begin
        pend = 1'b1;
        pv   = {w[i][27:16], w[i][13:0], 6'b0};
      end else if (slot < 4) begin
        eimm[slot] = pend ? (pv | {26'b0, w[i][5:0]}) : {18'b0, w[i][13:0]};
        ex[slot]   = pend;
        pend = 1'b0;
        slot++;
      end
    end
    for (int s = 0; s < 4; s++)
      chk_eq({tag, " R5 imm"}, pkt_imm[32*s +: 32], eimm[s]);
    chk_eq({tag, " R5 ext flags"}, pkt_ext, ex);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_is_ext = 1'b0; in_drain = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk_eq("R10 pkt_valid", pkt_valid, 0);
    chk_eq("R10 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R10 idle valid", pkt_valid, 0);

    for (int v = 0; v < NV; v++) begin
      send(VECS[v].n, VECS[v].ext, VECS[v].w);
      chk_eq("R1 pkt_valid", pkt_valid, 1);
      chk_eq("R1 in_ready low", in_ready, 0);
      chk_eq("R2 duplex", pkt_duplex, VECS[v].e_dup);
      chk_eq("R3 endloop0", pkt_endloop0, VECS[v].e_l0);
      chk_eq("R4 endloop1", pkt_endloop1, VECS[v].e_l1);
      chk_eq("R6 insns", pkt_insns, VECS[v].e_insns);
      chk_eq("R6 words", pkt_words, VECS[v].n);
      chk_eq("R9 bytes", pkt_bytes, 4 * VECS[v].n);
      chk_eq("R8 no error", pkt_error, 0);
      check_imms(VECS[v].n, VECS[v].ext, VECS[v].w, "vec");
      @(negedge clk);
      chk_eq("R1 single pulse", pkt_valid, 0);
    end

    // R1: mid words do not close the packet
    @(negedge clk);
    in_valid = 1'b1; in_word = 32'h0000_4001; @(posedge clk);
    @(negedge clk);
    in_word = 32'h0000_8002; @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_eq("R1 open packet", pkt_valid, 0);
    // R7 drain closes it as incomplete
    in_drain = 1'b1; @(posedge clk);
    @(negedge clk);
    in_drain = 1'b0;
    chk_eq("R7 valid", pkt_valid, 1);
    chk_eq("R7 incomplete", pkt_incomplete, 1);
    chk_eq("R7 words", pkt_words, 0);
    chk_eq("R7 insns", pkt_insns, 0);
    chk_eq("R7 loop flags", {pkt_endloop0, pkt_endloop1}, 0);
    @(negedge clk);
    // R7 drain with nothing collected
    in_drain = 1'b1; @(posedge clk);
    @(negedge clk);
    in_drain = 1'b0;
    chk_eq("R7 idle drain", pkt_valid, 0);

    // R8 fifth instruction overflows
    send(5, 5'b00000, {32'h0000_4005, 32'h0000_4004, 32'h0000_4003, 32'h0000_4002, 32'h0000_4001});
    chk_eq("R8 valid", pkt_valid, 1);
    chk_eq("R8 error", pkt_error, 1);
    chk_eq("R8 words", pkt_words, 5);
    chk_eq("R8 insns", pkt_insns, 4);
    check_imms(5, 5'b00000, {32'h0000_4005, 32'h0000_4004, 32'h0000_4003, 32'h0000_4002, 32'h0000_4001}, "R8");
    @(negedge clk);

    // R8 back-to-back extenders
    send(2, 5'b00011, {32'h0, 32'h0, 32'h0, 32'h0002_4010, 32'h0001_4020});
    chk_eq("R8 ext valid", pkt_valid, 1);
    chk_eq("R8 ext error", pkt_error, 1);
    chk_eq("R8 ext words", pkt_words, 2);
    chk_eq("R8 ext insns", pkt_insns, 0);
    @(negedge clk);

    // R6 clean packet after error
    send(1, 5'b00000, {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_C3FF});
    chk_eq("R6 recover insns", pkt_insns, 1);
    chk_eq("R8 recover error", pkt_error, 0);
    chk_eq("R5 recover imm", pkt_imm[31:0], 32'h0000_03FF);
    chk_eq("R5 recover ext", pkt_ext, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule